// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable 17-bit ratio using the pulse-swallow technique. The ratio is split into a 13-bit main count M (upper bits) and a 4-bit swallow count A (lower bits). A dual-modulus stage, modelled here in logic, divides by 17 while the swallow counter is non-zero and by 16 for the rest of the cycle. A full division cycle therefore spans 16·M + A stage ticks. An optional halving stage in front of the dual-modulus stage doubles the total ratio when it is enabled.

Each division cycle ends with a one-clock boundary strobe. At that strobe the block samples the ratio input, and a change of ratio in mid-cycle never alters the cycle in progress. Ratios below the smallest legal value of 240 are raised to 240 and flagged. The block also provides a registered divided pulse and a half-rate test signal that toggles once per cycle. The halving selection is meant to be set once and left alone.

Top module: `pulse_swallow_div`

## Requirements
- R1: With halve_en=0 and a ratio N with 240 <= N <= 131071, cycle_end pulses every N clocks; N = 16·M + A, where M = ratio_in[16:4] and A = ratio_in[3:0].
- R2: With halve_en=1, the spacing between cycle_end pulses is 2·N clocks, where N is the same clamped ratio.
- R3: The dual-modulus stage uses a modulus of 17 for the first A sub-periods of a cycle and 16 for the other M−A. A ratio with A=15 (for example 255 or 4111) therefore gives exactly N clocks, and so does a ratio with A=0 (for example 256).
- R4: A sampled ratio below 240 (including 0) runs as 240 and sets ratio_bad. A sampled ratio of 240 or more clears ratio_bad. ratio_bad changes only on the clock edge that ends a cycle.
- R5: ratio_in is sampled only at the edge where cycle_end is high. A change of ratio_in during a cycle leaves that cycle's length unchanged, and the new value applies from the following cycle.
- R6: cycle_end is high for exactly one clock per cycle, and consecutive pulses are at least 240 clocks apart.
- R7: fpd is a one-clock pulse that is high in the clock that follows each cycle_end pulse.
- R8: fpd_half inverts in the same clock that fpd is high and holds its value at all other times.
- R9: While rst_n is low, cycle_end, fpd, fpd_half and ratio_bad are 0. The first cycle after reset runs with ratio 240, so the first cycle_end appears 239 clocks after the release, counted from the clock in which rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| halve_en | input | 1 | Inserts the front divide-by-two stage (static setting) |
| ratio_in | input | 17 | Requested ratio: M in [16:4], A in [3:0] |
| cycle_end | output | 1 | One-clock boundary strobe; ratio_in is sampled here |
| fpd | output | 1 | Registered divided pulse, one clock after cycle_end |
| fpd_half | output | 1 | Test signal that toggles once per division cycle |
| ratio_bad | output | 1 | Set when the last sampled ratio was below 240 and clamped |

## Verification
The assertions assume that halve_en and ratio_in may change at any time. They rely only on the clamp, which keeps every cycle at 240 stage ticks or more, so the pulse-spacing and single-clock properties hold even across a change of the halving setting. The stimulus changes halve_en only in the clock that follows a boundary, lets the next boundary load the new ratio, and measures only the cycle after that, so each measured spacing reflects one stable setting. Ratios are kept small enough that every run stays short, with both A=0 and A=15 covered.

// File: rtl/pulse_swallow_div_pkg.sv
package pulse_swallow_div_pkg;

   // Smallest ratio for which the main count can always absorb the swallow count.
   function automatic int unsigned min_ratio(input int unsigned swallow_w);
      return ((32'd1 << swallow_w) - 32'd1) * (32'd1 << swallow_w);
   endfunction

   typedef enum logic {
      FRONT_BYPASS = 1'b0,
      FRONT_HALVE  = 1'b1
   } front_mode_e;

endpackage

// File: rtl/pulse_swallow_div_front.sv
module pulse_swallow_div_front #(
   parameter bit HAS_HALVER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halve_en,
   output logic tick
);
   import pulse_swallow_div_pkg::*;

   generate
      if (HAS_HALVER) begin : g_halver
         logic        phase;
         front_mode_e mode;
         assign mode = front_mode_e'(halve_en);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  phase <= 1'b0;
            else if (mode == FRONT_HALVE) phase <= ~phase;
            else                          phase <= 1'b0;
         end
         assign tick = (mode == FRONT_BYPASS) | phase;
      end else begin : g_direct
         logic unused_halve;
         assign unused_halve = halve_en;
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pulse_swallow_div_modulus.sv
module pulse_swallow_div_modulus #(
   parameter int unsigned SWALLOW_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic swallow,
   output logic mod_tick
);
   localparam int unsigned CW = SWALLOW_W + 1;
   localparam logic [CW-1:0] LAST_LO = CW'((1 << SWALLOW_W) - 1);
   localparam logic [CW-1:0] LAST_HI = CW'(1 << SWALLOW_W);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last     = swallow ? LAST_HI : LAST_LO;
   assign mod_tick = tick && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (mod_tick) cnt <= '0;
      else if (tick)     cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/pulse_swallow_div_ctrl.sv
module pulse_swallow_div_ctrl #(
   parameter int unsigned SWALLOW_W = 4,
   parameter int unsigned MAIN_W    = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mod_tick,
   input  logic [MAIN_W-1:0]    next_main,
   input  logic [SWALLOW_W-1:0] next_swallow,
   output logic                 swallow,
   output logic                 cycle_end
);
   localparam logic [MAIN_W-1:0] MAIN_RESET = MAIN_W'((1 << SWALLOW_W) - 1);

   logic [MAIN_W-1:0]    main_cnt;
   logic [SWALLOW_W-1:0] swal_cnt;

   assign swallow   = (swal_cnt != '0);
   assign cycle_end = mod_tick && (main_cnt == MAIN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_cnt <= MAIN_RESET;
         swal_cnt <= '0;
      end else if (cycle_end) begin
         main_cnt <= next_main;
         swal_cnt <= next_swallow;
      end else if (mod_tick) begin
         main_cnt <= main_cnt - MAIN_W'(1);
         if (swallow) swal_cnt <= swal_cnt - SWALLOW_W'(1);
      end
   end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
   parameter int unsigned SWALLOW_W  = 4,
   parameter int unsigned MAIN_W     = 13,
   parameter bit          HAS_HALVER = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          halve_en,
   input  logic [MAIN_W+SWALLOW_W-1:0]   ratio_in,
   output logic                          cycle_end,
   output logic                          fpd,
   output logic                          fpd_half,
   output logic                          ratio_bad
);
   import pulse_swallow_div_pkg::*;

   localparam int unsigned N_W = MAIN_W + SWALLOW_W;
   localparam logic [N_W-1:0] N_MIN = N_W'(min_ratio(SWALLOW_W));

   generate
      if (SWALLOW_W < 1) begin : g_bad_swallow
         $error("SWALLOW_W must be at least 1");
      end
      if (MAIN_W <= SWALLOW_W) begin : g_bad_main
         $error("MAIN_W must exceed SWALLOW_W");
      end
   endgenerate

   logic           tick, mod_tick, swallow, below_min;
   logic [N_W-1:0] eff_ratio;

   assign below_min = (ratio_in < N_MIN);
   assign eff_ratio = below_min ? N_MIN : ratio_in;

   pulse_swallow_div_front #(.HAS_HALVER(HAS_HALVER)) u_front (
      .clk(clk), .rst_n(rst_n), .halve_en(halve_en), .tick(tick)
   );

   pulse_swallow_div_modulus #(.SWALLOW_W(SWALLOW_W)) u_modulus (
      .clk(clk), .rst_n(rst_n), .tick(tick), .swallow(swallow), .mod_tick(mod_tick)
   );

   pulse_swallow_div_ctrl #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick),
      .next_main(eff_ratio[N_W-1:SWALLOW_W]),
      .next_swallow(eff_ratio[SWALLOW_W-1:0]),
      .swallow(swallow), .cycle_end(cycle_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpd       <= 1'b0;
         fpd_half  <= 1'b0;
         ratio_bad <= 1'b0;
      end else begin
         fpd <= cycle_end;
         if (cycle_end) begin
            fpd_half  <= ~fpd_half;
            ratio_bad <= below_min;
         end
      end
   end
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
   parameter int unsigned SWALLOW_W = 4,
   parameter int unsigned MAIN_W    = 13
) (
   input logic clk,
   input logic rst_n,
   input logic cycle_end,
   input logic fpd,
   input logic fpd_half,
   input logic ratio_bad
);
   localparam int unsigned GW = MAIN_W + SWALLOW_W + 2;
   localparam logic [GW-1:0] GAP_MIN = GW'(((1 << SWALLOW_W) - 1) * (1 << SWALLOW_W) - 1);

   logic [GW-1:0] gap;
   logic          seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (cycle_end) begin
         gap  <= '0;
         seen <= 1'b1;
      end else if (gap != '1) begin
         gap <= gap + GW'(1);
      end
   end

   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> !cycle_end);

   p_strobe_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_end && seen) |-> (gap >= GAP_MIN));

   p_fpd_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> fpd);

   p_fpd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> !fpd);

   p_half_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> (fpd_half != $past(fpd_half)));

   p_half_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(fpd_half));

   p_bad_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(ratio_bad));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .fpd(fpd),
   .fpd_half(fpd_half), .ratio_bad(ratio_bad)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halve_en = 1'b0;
   logic [16:0] ratio_in = 17'd1000;
   logic        cycle_end, fpd, fpd_half, ratio_bad;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pulse_swallow_div u_pulse_swallow_div (
      .clk(clk), .rst_n(rst_n), .halve_en(halve_en), .ratio_in(ratio_in),
      .cycle_end(cycle_end), .fpd(fpd), .fpd_half(fpd_half), .ratio_bad(ratio_bad)
   );

   // {halve_en, ratio, expected spacing, expected ratio_bad}
   localparam int NV = 11;
   localparam logic [36:0] VEC [NV] = '{
      {1'b0, 17'd240,  18'd240,  1'b0},   // R1 minimum legal
      {1'b0, 17'd255,  18'd255,  1'b0},   // R3 A=15
      {1'b0, 17'd256,  18'd256,  1'b0},   // R3 A=0
      {1'b0, 17'd1000, 18'd1000, 1'b0},   // R1
      {1'b1, 17'd240,  18'd480,  1'b0},   // R2
      {1'b1, 17'd777,  18'd1554, 1'b0},   // R2
      {1'b0, 17'd4111, 18'd4111, 1'b0},   // R3 M=256 A=15
      {1'b1, 17'd3000, 18'd6000, 1'b0},   // R2
      {1'b0, 17'd100,  18'd240,  1'b1},   // R4 clamp
      {1'b1, 17'd239,  18'd480,  1'b1},   // R4 clamp with halving
      {1'b0, 17'd0,    18'd240,  1'b1}    // R4 zero
   };

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!cycle_end);
   endtask

   task automatic measure(output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!cycle_end);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int cnt;
      logic old_half;
      // R9: reset values
      repeat (3) @(negedge clk);
      check("R9 cycle_end in reset", int'(cycle_end), 0);
      check("R9 fpd in reset", int'(fpd), 0);
      check("R9 fpd_half in reset", int'(fpd_half), 0);
      check("R9 ratio_bad in reset", int'(ratio_bad), 0);
      rst_n = 1'b1;
      // R9: first cycle runs at 240
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!cycle_end);
      check("R9 first strobe delay", cnt, 239);

      // Table walk: R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         halve_en = VEC[i][36];
         ratio_in = VEC[i][35:19];
         wait_strobe();
         measure(cnt);
         check($sformatf("R1/R2/R3 spacing vec %0d", i), cnt, int'(VEC[i][18:1]));
         check($sformatf("R4 ratio_bad vec %0d", i), int'(ratio_bad), int'(VEC[i][0]));
         wait_strobe();
      end

      // R4: legal ratio clears the flag
      halve_en = 1'b0;
      ratio_in = 17'd300;
      wait_strobe();
      measure(cnt);
      check("R4 flag cleared spacing", cnt, 300);
      check("R4 flag cleared", int'(ratio_bad), 0);

      // R5: mid-cycle change is deferred
      ratio_in = 17'd1000;
      wait_strobe();
      measure(cnt);
      check("R5 setup spacing", cnt, 1000);
      cnt = 0;
      repeat (100) begin
         @(negedge clk);
         cnt++;
      end
      ratio_in = 17'd500;
      do begin
         @(negedge clk);
         cnt++;
      end while (!cycle_end);
      check("R5 current cycle unchanged", cnt, 1000);
      measure(cnt);
      check("R5 new ratio next cycle", cnt, 500);

      // R6 R7 R8: pulse shapes around a boundary
      old_half = fpd_half;
      check("R7 fpd low at strobe", int'(fpd), 0);
      @(negedge clk);
      check("R6 strobe single clock", int'(cycle_end), 0);
      check("R7 fpd after strobe", int'(fpd), 1);
      check("R8 fpd_half toggled", int'(fpd_half), int'(!old_half));
      @(negedge clk);
      check("R7 fpd single clock", int'(fpd), 0);
      repeat (50) @(negedge clk);
      check("R8 fpd_half held", int'(fpd_half), int'(!old_half));

      finish_run();
   end
endmodule